// File: doc/BRIEF.md
# Pipelined Synchronous SRAM With Zero-Gap Read/Write Turnaround

The block is a synchronous single-port memory of 36-bit words, each word split into four 9-bit byte lanes. Every control, address and data input is registered on the rising clock edge, and read data leaves through an output register. A read, a write or a deselect can be issued on every clock. Write data is taken two enabled edges after its address, which means a read can follow a write with no idle cycle between them.

A read that targets a word whose write data is arriving in the same cycle gets the new bytes through a per-lane bypass. A single hold input freezes the whole pipeline, the array included. When the advance/load control is high, the operation type of the previous accepted cycle repeats, and the chip and write enables are ignored. In that case the address still comes from the address input, because an external sequencer produces burst addresses.

Top module: `flow_sram`

## Requirements
- R1: While hold_i is high, a rising edge changes nothing. The pipeline stages, the array, rdata_o and the read-valid state keep their values, and write data on wdata_i is ignored at that edge.
- R2: With hold_i low and ld_ni low, an edge starts an access only when ce1_ni is low, ce2_i is high and ce3_ni is low. we_ni high selects a read and we_ni low selects a write. Any other chip-enable combination is a deselect.
- R3: Data for a read issued at edge k appears on rdata_o after enabled edge k+1. drive_o equals the registered read-valid flag ANDed with the inverse of oe_ni, and it follows oe_ni without a clock.
- R4: A deselect at edge k makes drive_o low after edge k+1.
- R5: For a write issued at edge k, drive_o is low after edge k+1 whatever oe_ni is. The write data is sampled from wdata_i at enabled edge k+2.
- R6: Bit i of byte_wr_ni, when low, updates lane i, which is bits [9i+8:9i]. Lanes whose bit is high keep their old contents.
- R7: A new operation may be issued on every cycle. A read issued right after a write to the same address returns the newly written bytes, merged lane by lane with the stored bytes.
- R8: With hold_i low and ld_ni high, an edge repeats the operation type (read, write or deselect) accepted at the previous enabled edge, using the address on addr_i. The chip enables and we_ni are ignored.
- R9: While rst_ni is low, drive_o and rdata_o are 0 and the pipeline is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | High: ignore the edge and freeze all state |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| we_ni | input | 1 | Low: write, high: read |
| ld_ni | input | 1 | Low: load a new operation, high: repeat the previous operation type |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| byte_wr_ni | input | 4 | Per-lane write select, active low |
| addr_i | input | 8 | Word address |
| wdata_i | input | 36 | Write data, sampled two enabled edges after the address |
| rdata_o | output | 36 | Registered read data |
| drive_o | output | 1 | Data bus drive enable |

## Verification
The two functions that coincide are the commit of a write's data into the array and the loading of a later read into the output register. Both happen at the same edge when a read is issued in the cycle directly after a write to the same address. The bench provokes this with full and partial byte-lane writes, each followed at once by a read of that address, and with hold cycles placed inside the write's two-edge window. A scoreboard model applies each write at issue time and compares every read's output against it lane by lane.

// File: rtl/flow_sram_pkg.sv
package flow_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/flow_sram_array.sv
module flow_sram_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        ben_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [AW-1:0]           raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && ben_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/flow_sram_ctrl.sv
module flow_sram_ctrl
  import flow_sram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             ld_ni,
  input  logic             ce1_ni,
  input  logic             ce2_i,
  input  logic             ce3_ni,
  input  logic             we_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] ben_ni,
  output op_e              s1_op_o,
  output logic [AW-1:0]    s1_addr_o,
  output logic             s2_wr_o,
  output logic [AW-1:0]    s2_addr_o,
  output logic [LANES-1:0] s2_ben_o,
  output logic             rd_valid_o,
  output logic             arr_we_o
);
  logic             sel;
  op_e              nxt_op;
  logic [LANES-1:0] s1_ben;

  always_comb begin
    sel = ~ce1_ni & ce2_i & ~ce3_ni;
    if (ld_ni)    nxt_op = s1_op_o;  // advance: keep operation type
    else if (sel) nxt_op = we_ni ? OP_READ : OP_WRITE;
    else          nxt_op = OP_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op_o    <= OP_IDLE;
      s1_addr_o  <= '0;
      s1_ben     <= '0;
      s2_wr_o    <= 1'b0;
      s2_addr_o  <= '0;
      s2_ben_o   <= '0;
      rd_valid_o <= 1'b0;
    end else if (!hold_i) begin
      s1_op_o    <= nxt_op;
      s1_addr_o  <= addr_i;
      s1_ben     <= ~ben_ni;
      s2_wr_o    <= (s1_op_o == OP_WRITE);
      s2_addr_o  <= s1_addr_o;
      s2_ben_o   <= s1_ben;
      rd_valid_o <= (s1_op_o == OP_READ);
    end
  end

  assign arr_we_o = s2_wr_o & ~hold_i;

  p_stage_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(s1_op_o) && $stable(s2_wr_o) && $stable(rd_valid_o)));
  p_rd_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && s1_op_o == OP_READ) |=> rd_valid_o);
  p_desel_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && s1_op_o == OP_IDLE) |=> !rd_valid_o);
  p_wr_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && s1_op_o == OP_WRITE) |=> (!rd_valid_o && s2_wr_o));
  p_adv_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && ld_ni) |=> (s1_op_o == $past(s1_op_o)));
endmodule

// File: rtl/flow_sram.sv
module flow_sram
  import flow_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hold_i,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    we_ni,
  input  logic                    ld_ni,
  input  logic                    oe_ni,
  input  logic [LANES-1:0]        byte_wr_ni,
  input  logic [$clog2(DEPTH)-1:0] addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int WW = LANES * LANE_W;

  op_e              s1_op;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic             s2_wr, rd_valid, arr_we, hit;
  logic [LANES-1:0] s2_ben;
  logic [WW-1:0]    arr_rd, merged, rdata_q;

  flow_sram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .hold_i, .ld_ni, .ce1_ni, .ce2_i, .ce3_ni, .we_ni, .addr_i,
    .ben_ni     (byte_wr_ni),
    .s1_op_o    (s1_op),
    .s1_addr_o  (s1_addr),
    .s2_wr_o    (s2_wr),
    .s2_addr_o  (s2_addr),
    .s2_ben_o   (s2_ben),
    .rd_valid_o (rd_valid),
    .arr_we_o   (arr_we)
  );

  flow_sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_array (
    .clk_i,
    .we_i    (arr_we),
    .ben_i   (s2_ben),
    .waddr_i (s2_addr),
    .wdata_i (wdata_i),
    .raddr_i (s1_addr),
    .rdata_o (arr_rd)
  );

  // write data landing this edge overrides the stale array lanes
  assign hit = s2_wr && (s2_addr == s1_addr);
  for (genvar g = 0; g < LANES; g++) begin : g_byp
    assign merged[g*LANE_W +: LANE_W] = (hit && s2_ben[g]) ?
        wdata_i[g*LANE_W +: LANE_W] : arr_rd[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              rdata_q <= '0;
    else if (!hold_i && s1_op == OP_READ)     rdata_q <= merged;
  end

  assign rdata_o = rdata_q;
  assign drive_o = rd_valid & ~oe_ni;

  p_rdata_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(rdata_q));
  p_arr_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i || !s2_wr) |-> !arr_we);
endmodule

// File: tb/sim_flow_sram.sv
module sim_flow_sram;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hold_i = 1'b0;
  logic        ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic        we_ni = 1'b1, ld_ni = 1'b0, oe_ni = 1'b0;
  logic [3:0]  byte_wr_ni = 4'hF;
  logic [7:0]  addr_i = '0;
  logic [35:0] wdata_i = '0;
  logic [35:0] rdata_o;
  logic        drive_o;

  flow_sram u0 (.*);

  always #2 clk_i = ~clk_i;

  typedef struct packed { logic v; logic [35:0] d; } exp_t;
  exp_t        exp_q[$];
  string       tag_q[$];
  string       cur_tag = "R9";
  logic [35:0] mdl [256];
  logic [35:0] wd_pipe [2];
  int          last_op = 0;
  int          checks = 0, fails = 0;
  bit          run = 0;
  logic        last_drv = 1'b0;
  logic [35:0] last_rd = '0;

  // scoreboard monitor
  initial forever begin
    @(posedge clk_i); #1;
    if (run) begin
      if (hold_i) begin
        checks++;
        if (drive_o !== last_drv || rdata_o !== last_rd) begin
          fails++;
          $display("FAIL R1 hold: drive=%b rdata=%h expected drive=%b rdata=%h",
                   drive_o, rdata_o, last_drv, last_rd);
        end
      end else if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL %s scoreboard empty: drive=%b expected an entry", cur_tag, drive_o);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (drive_o !== (e.v & ~oe_ni)) begin
          fails++;
          $display("FAIL %s drive: actual=%b expected=%b", t, drive_o, e.v & ~oe_ni);
        end
        if (e.v) begin
          checks++;
          if (rdata_o !== e.d) begin
            fails++;
            $display("FAIL %s rdata: actual=%h expected=%h", t, rdata_o, e.d);
          end
        end
      end
      last_drv = drive_o;
      last_rd  = rdata_o;
    end
  end

  // driver: apply one command now, model it, advance to the next negedge
  task automatic cmd(input logic ld_n, input logic c1n, input logic c2, input logic c3n,
                     input logic we_n, input logic [7:0] a, input logic [3:0] bwn,
                     input logic [35:0] d);
    int   op;
    exp_t e;
    hold_i = 1'b0; ld_ni = ld_n; ce1_ni = c1n; ce2_i = c2; ce3_ni = c3n;
    we_ni = we_n; addr_i = a; byte_wr_ni = bwn;
    wdata_i = wd_pipe[1];
    if (ld_n)                   op = last_op;
    else if (!c1n && c2 && !c3n) op = we_n ? 1 : 2;
    else                        op = 0;
    if (op == 2)
      for (int l = 0; l < 4; l++)
        if (!bwn[l]) mdl[a][l*9 +: 9] = d[l*9 +: 9];
    e.v = (op == 1);
    e.d = mdl[a];
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
    wd_pipe[1] = wd_pipe[0];
    wd_pipe[0] = (op == 2) ? d : 36'hA_5A5A_5A5A;
    last_op = op;
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [7:0] a);
    cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, a, 4'hF, 36'h0);
  endtask
  task automatic wr(input logic [7:0] a, input logic [3:0] bwn, input logic [35:0] d);
    cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, bwn, d);
  endtask
  task automatic desel();
    cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0, 4'hF, 36'h0);
  endtask
  // advance with chip enables inactive and we low, which must be ignored
  task automatic adv(input logic [7:0] a, input logic [3:0] bwn, input logic [35:0] d);
    cmd(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, a, bwn, d);
  endtask
  task automatic hold(input int n);
    for (int i = 0; i < n; i++) begin
      hold_i = 1'b1; ld_ni = 1'b0; ce1_ni = 1'b0; ce2_i = 1'b1; ce3_ni = 1'b0;
      we_ni = 1'b0; byte_wr_ni = 4'h0; addr_i = 8'(i + 100);
      wdata_i = 36'hF_0F0F_0F0F;
      @(negedge clk_i);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wd_pipe[0] = 36'hA_5A5A_5A5A;
    wd_pipe[1] = 36'hA_5A5A_5A5A;
    #3;
    checks += 2; // R9 reset state
    if (drive_o !== 1'b0) begin fails++; $display("FAIL R9 drive: actual=%b expected=0", drive_o); end
    if (rdata_o !== '0) begin fails++; $display("FAIL R9 rdata: actual=%h expected=0", rdata_o); end
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_q.push_back('0);
    tag_q.push_back("R9");
    run = 1;

    cur_tag = "R2";  // chip-enable polarity: each wrong enable deselects
    cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 4'hF, 36'h0);
    cmd(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1, 4'hF, 36'h0);
    cmd(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1, 4'h0, 36'h1_2345_6789);

    cur_tag = "R5";  // back-to-back full writes, oe low: bus must stay off
    for (int i = 0; i < 8; i++) wr(8'(i), 4'h0, {4'(i), 32'hC0DE_0000 + 32'(i * 17)});

    cur_tag = "R3";
    for (int i = 0; i < 8; i++) rd(8'(i));

    cur_tag = "R6";  // lanes 0 and 2 only
    wr(8'd3, 4'b1010, 36'h1_FFFF_FFFF);
    desel();
    rd(8'd3);
    wr(8'd4, 4'b0111, 36'hE_EEEE_EEEE);
    desel();
    rd(8'd4);

    cur_tag = "R7";  // read right behind write, same address, bypass
    wr(8'd10, 4'h0, 36'h9_8765_4321);
    rd(8'd10);
    wr(8'd10, 4'b0110, 36'h0_1111_2222);
    rd(8'd10);
    wr(8'd11, 4'h0, 36'h3_3333_3333);
    rd(8'd2);
    wr(8'd12, 4'h0, 36'h4_4444_4444);
    rd(8'd11);
    rd(8'd12);
    wr(8'd12, 4'b1110, 36'h0_0000_01AB);
    rd(8'd12);

    cur_tag = "R4";
    rd(8'd1);
    desel();
    rd(8'd2);
    cmd(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd2, 4'hF, 36'h0);
    desel();

    cur_tag = "R3";  // oe high gates drive, data still registered
    oe_ni = 1'b1;
    rd(8'd5);
    rd(8'd6);
    desel();
    oe_ni = 1'b0;

    cur_tag = "R8";
    rd(8'd5);
    adv(8'd6, 4'hF, 36'h0);
    adv(8'd7, 4'hF, 36'h0);
    wr(8'd20, 4'h0, 36'h2_0202_0202);
    adv(8'd21, 4'h0, 36'h2_1212_1212);
    adv(8'd22, 4'b1100, 36'h2_2222_2222);
    desel();
    adv(8'd23, 4'h0, 36'h7_7777_7777);
    rd(8'd20);
    rd(8'd21);
    rd(8'd22);

    cur_tag = "R1";  // hold inside the write window and after a read
    wr(8'd30, 4'h0, 36'h3_0303_0303);
    hold(2);
    rd(8'd30);
    hold(3);
    rd(8'd1);
    rd(8'd30);
    hold(2);
    desel();

    cur_tag = "R4";
    desel();
    desel();
    desel();
    run = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule